// File: doc/BRIEF.md
# Credit-Based CPU Bandwidth Regulator

This block decides, cycle by cycle, whether a waiting CPU memory burst may be handed to the DDR arbiter while DMA traffic competes for the same memory. It keeps a saturating usage account for the CPU. CPU bursts charge the account, and it drains by a programmable step on every clock. While the account sits above a programmable hold level and any DMA request is pending, the CPU is held off, so DMA wins until the CPU's recent usage has drained away. When no DMA request is pending, the CPU is never held off.

Charging has two modes. In burst mode, one charge step is added when a CPU burst starts. In cycle mode, the charge step is added for every clock cycle the CPU burst occupies. The burst length is given in clock cycles; a burst of n 32-bit elements at double data rate takes n/2 cycles. A free level sits above the hold level: while the account is above it, CPU bursts add nothing. Software is expected to keep the free level at or above the hold level. The package holds the reset-time register values: hold level 0xFFFF, charge step 0x04, free level 0xFFFF and drain step 0x01.

Top module: `cpu_bw_regulator`

## Requirements
- R1: After reset the account is zero, so with cpu_req high, dma_pend high and hold_level zero, cpu_go is high.
- R2: cpu_go is high only when cpu_req is high. With cpu_req and dma_pend both high, cpu_go is low exactly when the account is strictly greater than hold_level; an account equal to hold_level still allows the burst.
- R3: With dma_pend low, cpu_go follows cpu_req whatever the account value.
- R4: The account drops by drain_step on every clock and never goes below zero.
- R5: With per_cycle_mode low, charge_step is added once in the cycle burst_start is high, and at no other time.
- R6: With per_cycle_mode high, charge_step is added in each cycle of a burst. A burst runs from the burst_start cycle for burst_len cycles, and a burst_len of 0 counts as one cycle. A burst_start during a running burst ends that burst and begins a new one with the new length.
- R7: While the account is strictly greater than free_level, no charge is added. An account equal to free_level is still charged.
- R8: In a cycle with both a charge and a drain, the next account is clamp(account + charge - drain), computed in that one cycle.
- R9: The account saturates at 2^ACC_W - 1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU has a burst waiting |
| dma_pend | input | 1 | At least one DMA request is waiting |
| burst_start | input | 1 | A CPU burst starts in this cycle |
| burst_len | input | LEN_W | Length of the starting burst in clock cycles |
| per_cycle_mode | input | 1 | 1: charge per burst cycle; 0: charge per burst |
| hold_level | input | LIM_W | Account level above which DMA wins |
| charge_step | input | STP_W | Amount charged per burst or per burst cycle |
| free_level | input | LIM_W | Account level above which bursts cost nothing |
| drain_step | input | STP_W | Amount drained every clock |
| cpu_go | output | 1 | CPU burst may be issued |

## Verification
The bench builds the block with the default 16-bit account, hold and free levels, 8-bit steps, and LEN_W set to 4. With this short length field, bursts of zero, one, two and three cycles, and a restart in the middle of a burst, all fit into a short table of vectors. The account is never read directly. It is found by sweeping hold_level around the expected value while DMA is pending. The 8-bit charge step, held at 255 with the drain at zero, reaches the 16-bit ceiling within about three hundred cycles, so saturation can be tested.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  // Register values software sees after reset
  localparam logic [15:0] RST_HOLD_LEVEL  = 16'hFFFF;
  localparam logic [7:0]  RST_CHARGE_STEP = 8'h04;
  localparam logic [15:0] RST_FREE_LEVEL  = 16'hFFFF;
  localparam logic [7:0]  RST_DRAIN_STEP  = 8'h01;

  typedef enum logic {
    CHG_PER_BURST = 1'b0,
    CHG_PER_CYCLE = 1'b1
  } charge_mode_e;

endpackage

// File: rtl/cbr_burst_track.sv
module cbr_burst_track #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);

  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] rem_d;

  // Cycles still to run after the current one
  always_comb begin
    if (start) begin
      rem_d = (len == '0) ? '0 : len - LEN_W'(1);
    end else if (rem_q != '0) begin
      rem_d = rem_q - LEN_W'(1);
    end else begin
      rem_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign busy = start | (rem_q != '0);

endmodule

// File: rtl/cbr_charge.sv
module cbr_charge
  import cbr_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int LIM_W = 16,
  parameter int STP_W = 8
) (
  input  logic [ACC_W-1:0] acct,
  input  logic [LIM_W-1:0] free_level,
  input  logic [STP_W-1:0] step,
  input  charge_mode_e     mode,
  input  logic             start,
  input  logic             busy,
  output logic             is_free,
  output logic [STP_W-1:0] charge
);

  function automatic logic [STP_W-1:0] pick_charge(
    input logic             free_now,
    input charge_mode_e     m,
    input logic             st,
    input logic             bz,
    input logic [STP_W-1:0] s
  );
    logic hit;
    hit = (m == CHG_PER_CYCLE) ? bz : st;
    return (free_now || !hit) ? '0 : s;
  endfunction

  assign is_free = acct > ACC_W'(free_level);
  assign charge  = pick_charge(is_free, mode, start, busy, step);

endmodule

// File: rtl/cbr_account.sv
module cbr_account #(
  parameter int ACC_W = 16,
  parameter int STP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STP_W-1:0] charge,
  input  logic [STP_W-1:0] drain,
  output logic [ACC_W-1:0] acct
);

  localparam int SW = ACC_W + 2;
  localparam logic [ACC_W-1:0] MAXV = {ACC_W{1'b1}};

  // Net update: add, take off the drain with a floor, then clamp at the top
  function automatic logic [ACC_W-1:0] step_acct(
    input logic [ACC_W-1:0] a,
    input logic [STP_W-1:0] c,
    input logic [STP_W-1:0] d
  );
    logic [SW-1:0] up;
    logic [SW-1:0] dn;
    up = SW'(a) + SW'(c);
    dn = (up < SW'(d)) ? '0 : up - SW'(d);
    return (dn > SW'(MAXV)) ? MAXV : dn[ACC_W-1:0];
  endfunction

  logic [ACC_W-1:0] acct_q;

  always_ff @(posedge clk) begin
    if (!rst_n) acct_q <= '0;
    else        acct_q <= step_acct(acct_q, charge, drain);
  end

  assign acct = acct_q;

endmodule

// File: rtl/cbr_gate.sv
module cbr_gate #(
  parameter int ACC_W = 16,
  parameter int LIM_W = 16
) (
  input  logic [ACC_W-1:0] acct,
  input  logic [LIM_W-1:0] hold_level,
  input  logic             cpu_req,
  input  logic             dma_pend,
  output logic             over,
  output logic             go
);

  assign over = acct > ACC_W'(hold_level);
  assign go   = cpu_req & ~(dma_pend & over);

endmodule

// File: rtl/cpu_bw_regulator.sv
module cpu_bw_regulator
  import cbr_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int LIM_W = 16,
  parameter int STP_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             dma_pend,
  input  logic             burst_start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             per_cycle_mode,
  input  logic [LIM_W-1:0] hold_level,
  input  logic [STP_W-1:0] charge_step,
  input  logic [LIM_W-1:0] free_level,
  input  logic [STP_W-1:0] drain_step,
  output logic             cpu_go
);

  // Named internal events, used by the bound checker
  logic             busy_cyc;
  logic             is_free;
  logic             over_hold;
  logic [STP_W-1:0] charge_amt;
  logic [ACC_W-1:0] acct_q;
  charge_mode_e     mode;

  assign mode = per_cycle_mode ? CHG_PER_CYCLE : CHG_PER_BURST;

  cbr_burst_track #(.LEN_W(LEN_W)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .start (burst_start),
    .len   (burst_len),
    .busy  (busy_cyc)
  );

  cbr_charge #(.ACC_W(ACC_W), .LIM_W(LIM_W), .STP_W(STP_W)) u_charge (
    .acct       (acct_q),
    .free_level (free_level),
    .step       (charge_step),
    .mode       (mode),
    .start      (burst_start),
    .busy       (busy_cyc),
    .is_free    (is_free),
    .charge     (charge_amt)
  );

  cbr_account #(.ACC_W(ACC_W), .STP_W(STP_W)) u_acct (
    .clk    (clk),
    .rst_n  (rst_n),
    .charge (charge_amt),
    .drain  (drain_step),
    .acct   (acct_q)
  );

  cbr_gate #(.ACC_W(ACC_W), .LIM_W(LIM_W)) u_gate (
    .acct       (acct_q),
    .hold_level (hold_level),
    .cpu_req    (cpu_req),
    .dma_pend   (dma_pend),
    .over       (over_hold),
    .go         (cpu_go)
  );

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int ACC_W = 16,
  parameter int LIM_W = 16,
  parameter int STP_W = 8,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             dma_pend,
  input logic             burst_start,
  input logic [LEN_W-1:0] burst_len,
  input logic             per_cycle_mode,
  input logic [LIM_W-1:0] free_level,
  input logic [STP_W-1:0] drain_step,
  input logic             cpu_go,
  input logic             busy_cyc,
  input logic [ACC_W-1:0] acct_q
);

  localparam logic [ACC_W-1:0] MAXV = {ACC_W{1'b1}};

  p_go_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |-> cpu_req);

  p_no_dma_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !dma_pend) |-> cpu_go);

  p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_cyc && acct_q >= ACC_W'(drain_step))
      |=> acct_q == $past(acct_q) - ACC_W'($past(drain_step)));

  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_cyc && acct_q < ACC_W'(drain_step)) |=> acct_q == '0);

  p_once_per_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_cycle_mode && !burst_start) |=> acct_q <= $past(acct_q));

  p_burst_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && burst_len > LEN_W'(1)) |=> busy_cyc);

  p_free_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acct_q > ACC_W'(free_level)) |=> acct_q <= $past(acct_q));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acct_q == MAXV && drain_step == '0) |=> acct_q == MAXV);

endmodule

bind cpu_bw_regulator cbr_checker #(
  .ACC_W(ACC_W), .LIM_W(LIM_W), .STP_W(STP_W), .LEN_W(LEN_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_req        (cpu_req),
  .dma_pend       (dma_pend),
  .burst_start    (burst_start),
  .burst_len      (burst_len),
  .per_cycle_mode (per_cycle_mode),
  .free_level     (free_level),
  .drain_step     (drain_step),
  .cpu_go         (cpu_go),
  .busy_cyc       (busy_cyc),
  .acct_q         (acct_q)
);

// File: tb/sim_cpu_bw_regulator.sv
`timescale 1ns/1ps
module sim_cpu_bw_regulator;

  localparam int ACC_W = 16;
  localparam int LIM_W = 16;
  localparam int STP_W = 8;
  localparam int LEN_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cpu_req = 1'b0;
  logic             dma_pend = 1'b0;
  logic             burst_start = 1'b0;
  logic [LEN_W-1:0] burst_len = '0;
  logic             per_cycle_mode = 1'b0;
  logic [LIM_W-1:0] hold_level = 16'hFFFF;
  logic [STP_W-1:0] charge_step = 8'h04;
  logic [LIM_W-1:0] free_level = 16'hFFFF;
  logic [STP_W-1:0] drain_step = 8'h01;
  logic             cpu_go;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cpu_bw_regulator #(.ACC_W(ACC_W), .LIM_W(LIM_W), .STP_W(STP_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_pend(dma_pend),
    .burst_start(burst_start), .burst_len(burst_len), .per_cycle_mode(per_cycle_mode),
    .hold_level(hold_level), .charge_step(charge_step), .free_level(free_level),
    .drain_step(drain_step), .cpu_go(cpu_go)
  );

  typedef struct packed {
    logic             st;
    logic [LEN_W-1:0] len;
    logic             cyc;
    logic [7:0]       stp;
    logic [7:0]       drn;
    logic [15:0]      fre;
    logic [15:0]      exp_acct;
  } vec_t;

  // One cycle per vector; expected account after that cycle's edge
  localparam vec_t VT [15] = '{
    '{1'b1, 4'd3, 1'b0, 8'd10, 8'd1,  16'hFFFF, 16'd9},   // R8 net change
    '{1'b0, 4'd0, 1'b0, 8'd10, 8'd1,  16'hFFFF, 16'd8},   // R5 no charge mid-burst
    '{1'b0, 4'd0, 1'b0, 8'd10, 8'd1,  16'hFFFF, 16'd7},   // R4
    '{1'b1, 4'd2, 1'b1, 8'd5,  8'd1,  16'hFFFF, 16'd11},  // R6 first cycle
    '{1'b0, 4'd0, 1'b1, 8'd5,  8'd1,  16'hFFFF, 16'd15},  // R6 second cycle
    '{1'b0, 4'd0, 1'b1, 8'd5,  8'd1,  16'hFFFF, 16'd14},  // R6 burst over
    '{1'b0, 4'd0, 1'b0, 8'd5,  8'd20, 16'hFFFF, 16'd0},   // R4 floor
    '{1'b1, 4'd1, 1'b1, 8'd3,  8'd3,  16'hFFFF, 16'd0},   // R8
    '{1'b1, 4'd0, 1'b0, 8'd8,  8'd2,  16'hFFFF, 16'd6},   // R5
    '{1'b0, 4'd0, 1'b1, 8'd8,  8'd2,  16'hFFFF, 16'd4},   // R6 len 0 = one cycle
    '{1'b1, 4'd0, 1'b0, 8'd9,  8'd1,  16'd3,    16'd3},   // R7 above free level
    '{1'b1, 4'd0, 1'b0, 8'd9,  8'd1,  16'd3,    16'd11},  // R7 equal still charged
    '{1'b1, 4'd3, 1'b1, 8'd2,  8'd1,  16'hFFFF, 16'd12},  // R6
    '{1'b1, 4'd1, 1'b1, 8'd2,  8'd1,  16'hFFFF, 16'd13},  // R6 restart
    '{1'b0, 4'd0, 1'b1, 8'd2,  8'd1,  16'hFFFF, 16'd12}   // R6 restart cut burst
  };

  task automatic report(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Account probe through the grant: hold_level = e allows, e-1 holds off
  task automatic probe_acct(input int e, input string req);
    logic [LIM_W-1:0] sv_hold;
    logic sv_dma, sv_req, g_at, g_below;
    sv_hold = hold_level; sv_dma = dma_pend; sv_req = cpu_req;
    cpu_req = 1'b1; dma_pend = 1'b1;
    hold_level = LIM_W'(e); #0.2; g_at = cpu_go;
    g_below = 1'b0;
    if (e > 0) begin hold_level = LIM_W'(e - 1); #0.2; g_below = cpu_go; end
    report(g_at === 1'b1 && g_below === 1'b0, req, {g_at, g_below}, 2);
    hold_level = sv_hold; dma_pend = sv_dma; cpu_req = sv_req;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    cpu_req = 1'b1; dma_pend = 1'b1; hold_level = '0; #0.2;
    report(cpu_go === 1'b1, "R1", cpu_go, 1);
    @(negedge clk); rst_n = 1'b1; cpu_req = 1'b0; dma_pend = 1'b0;
    drain_step = '0;
    @(posedge clk); #1;
    probe_acct(0, "R1");
    drain_step = 8'h01;

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      burst_start = VT[i].st; burst_len = VT[i].len; per_cycle_mode = VT[i].cyc;
      charge_step = VT[i].stp; drain_step = VT[i].drn; free_level = VT[i].fre;
      @(posedge clk); #1;
      burst_start = 1'b0;
      probe_acct(int'(VT[i].exp_acct), $sformatf("R4-R8 vector %0d", i));
    end

    // R9: saturation at the top
    @(negedge clk);
    per_cycle_mode = 1'b0; charge_step = 8'd255; drain_step = 8'd0;
    free_level = 16'hFFFF; burst_start = 1'b1; burst_len = '0;
    repeat (300) @(posedge clk);
    #1; burst_start = 1'b0;
    probe_acct(65535, "R9");

    // R2: DMA wins above hold level, equal level and no request
    hold_level = 16'd100; dma_pend = 1'b1; cpu_req = 1'b1; #0.2;
    report(cpu_go === 1'b0, "R2 held", cpu_go, 0);
    // R3: no DMA, always allowed
    dma_pend = 1'b0; #0.2;
    report(cpu_go === 1'b1, "R3", cpu_go, 1);
    cpu_req = 1'b0; #0.2;
    report(cpu_go === 1'b0, "R2 no request", cpu_go, 0);
    hold_level = 16'hFFFF; dma_pend = 1'b1; cpu_req = 1'b1; #0.2;
    report(cpu_go === 1'b1, "R2 equal level", cpu_go, 1);

    finish_run();
  end

endmodule